// File: doc/BRIEF.md
# SPI Register Access Slave

This block is the serial front end of a register file. An external host opens a transaction by pulling chip select low. It then clocks in a two-byte header on the serial input. The header carries a read/write flag and an 11-bit register address. A single data byte follows. On a write, the block collects that byte from the serial input and issues one write strobe on a simple synchronous register bus. On a read, it issues one read strobe, captures the returned byte and shifts it out on the serial output. Each output bit changes on a falling serial-clock edge.

All SPI pins are brought into the system clock domain through synchronisers, and the block detects clock and chip-select edges there. The serial clock must therefore be slow against the system clock: each serial-clock phase must last at least SYNC_STAGES + 3 system cycles. The register bus expects `rb_rdata` to be valid in the same cycle as `rb_rd`. The serial output has a separate enable, so a pad driver can turn it into a tri-state pin.

Top module: `spi_regbus_slave`

## Requirements
- R1: While reset is held and just after it is released, `spi_miso_oe`, `rb_wr` and `rb_rd` are low.
- R2: The first header byte carries the instruction flag in bit 7 and address bits 10..8 in bits 2..0. The second header byte carries address bits 7..0. Both bytes arrive MSB first, sampled on rising serial-clock edges while chip select is low. The decoded address appears on `rb_addr` when the strobe fires.
- R3: Bits 6..3 of the first header byte do not affect the decoded address or the operation.
- R4: A flag of 0 selects a write. After the 24th rising edge, `rb_wr` pulses for exactly one system cycle, with `rb_wdata` equal to the data byte received MSB first. A write transaction produces no `rb_rd`.
- R5: A flag of 1 selects a read. After the 16th rising edge, `rb_rd` pulses exactly once for one system cycle. A read transaction produces no `rb_wr`.
- R6: On a read, the byte seen on `rb_rdata` during `rb_rd` is driven MSB first on `spi_miso`. Each bit is updated after a falling edge, and the eight bits are valid at rising edges 17 to 24.
- R7: `spi_miso_oe` is low during the 16 header bits, during write transactions, after the falling edge that follows rising edge 24, and while chip select is high.
- R8: If chip select rises before the 24th rising edge, no write strobe is issued. If it rises before the 16th, no read strobe is issued either. The next transaction decodes from its first bit.
- R9: If chip select rises in the same system cycle in which the 24th rising edge is detected, the transaction is abandoned and no write strobe is issued.
- R10: Rising edges after the 24th in the same transaction produce no further strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial read data to the host |
| spi_miso_oe | output | 1 | Output enable for the serial-out pad driver |
| rb_addr | output | ADDR_W | Register address decoded from the header |
| rb_wdata | output | DATA_W | Write data byte |
| rb_wr | output | 1 | One-cycle write strobe |
| rb_rd | output | 1 | One-cycle read strobe |
| rb_rdata | input | DATA_W | Read data, valid while `rb_rd` is high |

## Verification
Two events can fall in the same system cycle: completion of the last data bit and the end of the transaction. Chip select and the serial clock pass through synchronisers of equal depth, so the bench raises chip select in the same time step as the 24th serial-clock rise. Both edges then reach the control logic together. The bench judges the outcome by seeing no write strobe. A normal write to a different address that follows must then decode and commit correctly, which shows the bit counter was cleared by the abandoned transaction.

// File: rtl/spi_regbus_pkg.sv
// Shared constants and types for the SPI register access slave.
package spi_regbus_pkg;
    // Header length in serial bits: a command byte and an address byte.
    localparam int HDR_BITS = 16;

    // Transaction phase of the frame controller.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HDR   = 3'd1,
        ST_WDATA = 3'd2,
        ST_RDATA = 3'd3,
        ST_DONE  = 3'd4
    } frame_st_t;
endpackage

// File: rtl/spi_bit_sync.sv
// Multi-stage synchroniser for one asynchronous input bit.
// Assumes STAGES >= 2; RST_VAL is the idle level of the pin.
module spi_bit_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the pin level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_edge_front.sv
// Brings chip select, serial clock and serial input into the system clock
// domain and derives serial-clock edge pulses and the chip-select active level.
// Assumes all three pins see the same synchroniser depth, so bits stay aligned
// with the clock edges they belong to.
module spi_edge_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_csn,
    input  logic spi_sclk,
    input  logic spi_mosi,
    output logic cs_act,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_s
);
    logic csn_s;
    logic sclk_s;
    logic sclk_q;

    // One synchroniser per pin; idle levels: csn high, sclk and mosi low.
    spi_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csn (
        .clk(clk), .rst_n(rst_n), .d(spi_csn), .q(csn_s)
    );
    spi_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .d(spi_sclk), .q(sclk_s)
    );
    spi_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
        .clk(clk), .rst_n(rst_n), .d(spi_mosi), .q(mosi_s)
    );

    // Remember the previous synchronised clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    assign cs_act    = ~csn_s;
    assign sclk_rise = sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s & sclk_q;
endmodule

// File: rtl/spi_frame_ctl.sv
// Frame controller: counts serial bits, decodes the two-byte header, collects
// the write byte and issues the register-bus strobes.
// Assumes the address high part fits in the command byte below the flag bit
// (9 <= ADDR_W <= 11). A chip-select release seen in the same cycle as a clock
// edge wins over that edge.
module spi_frame_ctl
    import spi_regbus_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              mosi_s,
    output logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_wdata,
    output logic              rb_wr,
    output logic              rb_rd
);
    localparam int FRAME_BITS = HDR_BITS + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int AH         = ADDR_W - 8;
    localparam int SH_W       = HDR_BITS - 1;

    frame_st_t         st;
    logic [CNT_W-1:0]  bit_cnt;
    logic [SH_W-1:0]   sh;
    logic              hdr_last;
    logic              frame_last;
    logic              flag_rd;
    logic [ADDR_W-1:0] addr_dec;

    // Decode taps on the shift register as the last header bit arrives.
    assign hdr_last   = (bit_cnt == CNT_W'(HDR_BITS - 1));
    assign frame_last = (bit_cnt == CNT_W'(FRAME_BITS - 1));
    assign flag_rd    = sh[SH_W-1];
    assign addr_dec   = {sh[7+AH-1:7], sh[6:0], mosi_s};

    // Bit counting, header decode and strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            bit_cnt  <= '0;
            sh       <= '0;
            rb_addr  <= '0;
            rb_wdata <= '0;
            rb_wr    <= 1'b0;
            rb_rd    <= 1'b0;
        end else begin
            rb_wr <= 1'b0;
            rb_rd <= 1'b0;
            if (!cs_act) begin
                st      <= ST_IDLE;
                bit_cnt <= '0;
            end else if (st == ST_IDLE) begin
                st      <= ST_HDR;
                bit_cnt <= '0;
            end else if (sclk_rise) begin
                case (st)
                    ST_HDR: begin
                        sh      <= {sh[SH_W-2:0], mosi_s};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (hdr_last) begin
                            rb_addr <= addr_dec;
                            if (flag_rd) begin
                                st    <= ST_RDATA;
                                rb_rd <= 1'b1;
                            end else begin
                                st <= ST_WDATA;
                            end
                        end
                    end
                    ST_WDATA: begin
                        sh      <= {sh[SH_W-2:0], mosi_s};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (frame_last) begin
                            rb_wdata <= {sh[DATA_W-2:0], mosi_s};
                            rb_wr    <= 1'b1;
                            st       <= ST_DONE;
                        end
                    end
                    ST_RDATA: begin
                        bit_cnt <= bit_cnt + 1'b1;
                        if (frame_last) st <= ST_DONE;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_tx_shift.sv
// Read-data shifter: loads the register-bus read data and presents it MSB
// first, one bit per falling serial-clock edge, with its own output enable.
// Assumes the load arrives before the first falling edge after the header.
module spi_tx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_fall,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              miso,
    output logic              miso_oe
);
    localparam int SENT_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] sh;
    logic [SENT_W-1:0] sent;
    logic              armed;
    logic              oe;

    // Load, present and advance read bits on falling edges; release after the last.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            sh    <= '0;
            sent  <= '0;
            armed <= 1'b0;
            oe    <= 1'b0;
        end else if (load) begin
            sh    <= load_data;
            sent  <= '0;
            armed <= 1'b1;
        end else if (sclk_fall && armed) begin
            if (!oe && sent == '0) begin
                oe   <= 1'b1;
                sent <= SENT_W'(1);
            end else if (sent < SENT_W'(DATA_W)) begin
                sh   <= {sh[DATA_W-2:0], 1'b0};
                sent <= sent + 1'b1;
            end else begin
                oe    <= 1'b0;
                armed <= 1'b0;
            end
        end
    end

    assign miso    = oe & sh[DATA_W-1];
    assign miso_oe = oe;
endmodule

// File: rtl/spi_regbus_slave.sv
// Top: SPI slave giving a host byte-wide read/write access to a register bus.
// Assumes each serial-clock phase lasts at least SYNC_STAGES + 3 system cycles
// and that rb_rdata is valid in the cycle rb_rd is high.
module spi_regbus_slave #(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_csn,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_wdata,
    output logic              rb_wr,
    output logic              rb_rd,
    input  logic [DATA_W-1:0] rb_rdata
);
    logic cs_act;
    logic sclk_rise;
    logic sclk_fall;
    logic mosi_s;

    spi_edge_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst_n(rst_n),
        .spi_csn(spi_csn), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .cs_act(cs_act), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .mosi_s(mosi_s)
    );

    spi_frame_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .cs_act(cs_act), .sclk_rise(sclk_rise), .mosi_s(mosi_s),
        .rb_addr(rb_addr), .rb_wdata(rb_wdata), .rb_wr(rb_wr), .rb_rd(rb_rd)
    );

    spi_tx_shift #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .cs_act(cs_act), .sclk_fall(sclk_fall),
        .load(rb_rd), .load_data(rb_rdata),
        .miso(spi_miso), .miso_oe(spi_miso_oe)
    );
endmodule

// File: rtl/spi_regbus_slave_chk.sv
// Protocol checker for spi_regbus_slave, attached with bind below.
module spi_regbus_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_act,
    input logic sclk_fall,
    input logic miso,
    input logic miso_oe,
    input logic rb_wr,
    input logic rb_rd
);
    // R4
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_wr |=> !rb_wr);

    // R5
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_rd |=> !rb_rd);

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rb_wr && rb_rd));

    // R8
    wr_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_wr |-> $past(cs_act));

    // R7
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !miso_oe);

    // R6
    miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe && $past(miso_oe) && !$past(sclk_fall)) |-> $stable(miso));
endmodule

bind spi_regbus_slave spi_regbus_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_fall(sclk_fall),
    .miso(spi_miso), .miso_oe(spi_miso_oe), .rb_wr(rb_wr), .rb_rd(rb_rd)
);

// File: tb/sim_spi_regbus_slave.sv
module sim_spi_regbus_slave;
    localparam int H = 8;   // system cycles per serial-clock phase

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_csn = 1'b1;
    logic        spi_sclk = 1'b0;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        spi_miso_oe;
    logic [10:0] rb_addr;
    logic [7:0]  rb_wdata;
    logic        rb_wr;
    logic        rb_rd;
    logic [7:0]  rb_rdata;

    int total = 0;
    int bad = 0;
    int wr_n = 0;
    int rd_n = 0;
    logic [10:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [10:0] rd_addr = '0;

    always #10 clk = ~clk;   // 50 MHz

    spi_regbus_slave u0 (
        .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .rb_addr(rb_addr), .rb_wdata(rb_wdata), .rb_wr(rb_wr), .rb_rd(rb_rd),
        .rb_rdata(rb_rdata)
    );

    // Register-file model: read data is a fixed function of the address.
    function automatic logic [7:0] rd_model(input logic [10:0] a);
        return a[7:0] ^ {a[10:8], 5'b01101};
    endfunction
    assign rb_rdata = rd_model(rb_addr);

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rb_wr) begin wr_n++; wr_addr = rb_addr; wr_data = rb_wdata; end
            if (rb_rd) begin rd_n++; rd_addr = rb_addr; end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One transaction: nbits clocks; cs_last raises chip select with the last rise.
    task automatic xfer(input logic [23:0] f, input int nbits, input bit cs_last,
                        output logic [7:0] rx, output int oe_hdr, output logic oe_tail);
        rx = '0; oe_hdr = 0; oe_tail = 1'b0;
        spi_csn = 1'b0;
        wait_clk(H);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 24) ? f[23-i] : 1'b0;
            wait_clk(H);
            if (i < 16 && spi_miso_oe) oe_hdr++;
            if (i >= 16 && i < 24) rx = {rx[6:0], spi_miso};
            if (i == 24) oe_tail = spi_miso_oe;
            spi_sclk = 1'b1;
            if (cs_last && i == nbits - 1) spi_csn = 1'b1;
            wait_clk(H);
            spi_sclk = 1'b0;
        end
        wait_clk(H);
        spi_csn = 1'b1;
        wait_clk(2 * H);
    endtask

    // Vectors: {frame[23:0], expected address[10:0]}.
    localparam int NV = 6;
    localparam logic [34:0] VEC [NV] = '{
        {24'h05A53C, 11'h5A5},
        {24'h85A500, 11'h5A5},
        {24'h7FFF81, 11'h7FF},
        {24'hF80000, 11'h000},
        {24'h020000, 11'h200},
        {24'hD3C100, 11'h3C1}
    };

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rx;
        int         oeh;
        logic       oet;
        int         w0;
        int         r0;

        // R1: reset state, during and after reset
        wait_clk(4);
        chk(!spi_miso_oe && !rb_wr && !rb_rd, "R1 in reset", {spi_miso_oe, rb_wr, rb_rd}, 0);
        rst_n = 1'b1;
        wait_clk(4);
        chk(!spi_miso_oe && !rb_wr && !rb_rd, "R1 after reset", {spi_miso_oe, rb_wr, rb_rd}, 0);

        // Table walk: writes and reads, some with ignored command bits set.
        for (int v = 0; v < NV; v++) begin
            logic [23:0] f;
            logic [10:0] ea;
            string       areq;
            f  = VEC[v][34:11];
            ea = VEC[v][10:0];
            areq = (f[22:19] != 4'h0) ? "R3 addr" : "R2 addr";
            w0 = wr_n; r0 = rd_n;
            xfer(f, 24, 1'b0, rx, oeh, oet);
            chk(oeh == 0, "R7 header oe", oeh, 0);
            chk(!spi_miso_oe, "R7 idle oe", spi_miso_oe, 0);
            if (f[23]) begin
                chk(rd_n - r0 == 1, "R5 rd count", rd_n - r0, 1);
                chk(wr_n == w0, "R5 no wr", wr_n - w0, 0);
                chk(rd_addr == ea, areq, rd_addr, ea);
                chk(rx == rd_model(ea), "R6 data", rx, rd_model(ea));
            end else begin
                chk(wr_n - w0 == 1, "R4 wr count", wr_n - w0, 1);
                chk(rd_n == r0, "R4 no rd", rd_n - r0, 0);
                chk(wr_addr == ea, areq, wr_addr, ea);
                chk(wr_data == f[7:0], "R4 data", wr_data, f[7:0]);
            end
        end

        // R8: write abandoned after 20 bits, then a clean write
        w0 = wr_n;
        xfer(24'h0123AB, 20, 1'b0, rx, oeh, oet);
        chk(wr_n == w0, "R8 aborted write", wr_n - w0, 0);
        xfer(24'h0144C3, 24, 1'b0, rx, oeh, oet);
        chk(wr_n - w0 == 1 && wr_addr == 11'h144 && wr_data == 8'hC3,
            "R8 write after abort", {wr_addr, wr_data}, {11'h144, 8'hC3});

        // R8: read abandoned after 12 bits, then a clean read
        r0 = rd_n;
        xfer(24'h845600, 12, 1'b0, rx, oeh, oet);
        chk(rd_n == r0, "R8 aborted read", rd_n - r0, 0);
        xfer(24'h845600, 24, 1'b0, rx, oeh, oet);
        chk(rd_n - r0 == 1 && rx == rd_model(11'h456), "R8 read after abort",
            rx, rd_model(11'h456));

        // R9: chip select rises with the 24th rising edge
        w0 = wr_n;
        xfer(24'h06F05A, 24, 1'b1, rx, oeh, oet);
        chk(wr_n == w0, "R9 coincident release", wr_n - w0, 0);
        xfer(24'h011122, 24, 1'b0, rx, oeh, oet);
        chk(wr_n - w0 == 1 && wr_addr == 11'h111 && wr_data == 8'h22,
            "R9 next write", {wr_addr, wr_data}, {11'h111, 8'h22});

        // R10: extra clocks after the frame
        w0 = wr_n;
        xfer(24'h03335A, 28, 1'b0, rx, oeh, oet);
        chk(wr_n - w0 == 1 && wr_data == 8'h5A, "R10 write extra clocks", wr_n - w0, 1);
        r0 = rd_n;
        xfer(24'h817700, 26, 1'b0, rx, oeh, oet);
        chk(rd_n - r0 == 1, "R10 read extra clocks", rd_n - r0, 1);
        chk(!oet, "R7 oe released after last bit", oet, 0);
        chk(rx == rd_model(11'h177), "R6 data extra clocks", rx, rd_model(11'h177));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule